// File: doc/BRIEF.md
# In-Order Issue Hazard Scoreboard

This block sits at the issue stage of an in-order pipeline that feeds four execution units: integer, add, multiply and divide. Each unit class has its own fixed result latency. Each cycle the block may be offered one decoded instruction. The instruction carries a unit class, an optional destination register and two source registers. The block decides whether that instruction may dispatch in this cycle or must stall.

The decision comes from three pieces of state:
- a write-pending bit per architectural register;
- a busy bit per unit class;
- a booking vector of future writeback cycles, which keeps the single register write port from being claimed twice in the same cycle.

Writeback notifications clear pending bits. Unit-free pulses clear busy bits. Hazards of the write-after-read kind are not checked: issue is in order and operands are read at issue, so that hazard cannot arise.

The verdict is registered. It appears on the outputs in the cycle after the instruction was offered, as a grant or a stall together with a one-hot code for the chosen unit.

Top module: `issue_scoreboard`

## Requirements
- R1: After synchronous reset, `iss_ok`, `iss_stall` and `iss_unit` are 0, and all pending bits, busy bits and writeback bookings are clear, so the first instruction with free registers is granted.
- R2: The outputs show the verdict on the instruction offered in the previous cycle.
  - A granted instruction gives `iss_ok`=1 and `iss_unit` one-hot with bit index equal to the unit code (0 integer, 1 add, 2 multiply, 3 divide).
  - A refused instruction gives `iss_stall`=1 and `iss_unit`=0.
  - With no instruction offered, all three outputs are 0.
- R3: An instruction stalls while the busy bit of its unit class is set. A grant sets that busy bit, and a pulse on `unit_free[k]` clears busy bit k.
- R4: An instruction stalls when the pending bit of either source register is set (read-after-write).
- R5: An instruction with a destination stalls when the pending bit of that destination is set (write-after-write).
- R6: An instruction with a destination stalls when its writeback cycle, given by the fixed latency of its unit class (parameters LAT_INT, LAT_ADD, LAT_MUL, LAT_DIV), is already booked by an earlier grant.
- R7: A grant with a destination sets that register's pending bit. A `wb_valid` notification clears the pending bit of `wb_reg`. When both hit the same register in one cycle, the bit ends up set.
- R8: An instruction without a destination (`in_has_dst`=0) skips the write-after-write and writeback-slot checks. It sets no pending bit and books no writeback cycle.
- R9: A writeback notification or unit-free pulse takes effect from the next cycle on. An instruction offered in the same cycle is still judged on the old state.
- R10: No write-after-read check is made. An instruction whose destination is a source of an earlier granted instruction is granted when no other hazard applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| in_unit | input | 2 | Unit class code of the offered instruction |
| in_has_dst | input | 1 | Offered instruction writes a register |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| wb_valid | input | 1 | A register write reached writeback |
| wb_reg | input | REG_W | Register written back |
| unit_free | input | 4 | Per-class pulse: unit is available again |
| iss_ok | output | 1 | Previous-cycle instruction was granted |
| iss_stall | output | 1 | Previous-cycle instruction was refused |
| iss_unit | output | 4 | One-hot unit chosen for the granted instruction |

## Verification
The hardest case to reach from the ports is a writeback-slot collision. In that case no register or unit hazard is present, but a shorter-latency instruction would land on the same future cycle as a longer one granted earlier. The stimulus issues a multiply, frees its unit, and then offers an add exactly two cycles later on unrelated registers, so only the booking can refuse it. The same booked cycle is then met by a no-destination instruction, which must pass. The same-cycle cases (writeback beside issue, free beside offer, clear beside set) are each placed on one exact cycle, so the effect only becomes visible on the following instruction.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NUM_UNITS = 4;
  localparam int UNIT_W    = 2;

  typedef enum logic [UNIT_W-1:0] {
    U_INT = 2'd0,
    U_ADD = 2'd1,
    U_MUL = 2'd2,
    U_DIV = 2'd3
  } unit_e;
endpackage

// File: rtl/sb_pending.sv
module sb_pending #(
  parameter int NREG  = 32,
  parameter int REG_W = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [REG_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [REG_W-1:0] clr_idx,
  output logic [NREG-1:0]  pend
);
  for (genvar i = 0; i < NREG; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        pend[i] <= 1'b0;
      else if (set_en && set_idx == REG_W'(i))
        pend[i] <= 1'b1;
      else if (clr_en && clr_idx == REG_W'(i))
        pend[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/sb_unit_busy.sv
module sb_unit_busy
  import sb_pkg::*;
#(
  parameter int NU = NUM_UNITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              claim_en,
  input  logic [UNIT_W-1:0] claim_idx,
  input  logic [NU-1:0]     free,
  output logic [NU-1:0]     busy
);
  for (genvar k = 0; k < NU; k++) begin : g_unit
    always_ff @(posedge clk) begin
      if (rst)
        busy[k] <= 1'b0;
      else if (claim_en && claim_idx == UNIT_W'(k))
        busy[k] <= 1'b1;
      else if (free[k])
        busy[k] <= 1'b0;
    end
  end
endmodule

// File: rtl/sb_wb_slots.sv
module sb_wb_slots #(
  parameter int MAXLAT = 6,
  parameter int LW     = $clog2(MAXLAT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          book_en,
  input  logic [LW-1:0] book_lat,
  input  logic [LW-1:0] check_lat,
  output logic          taken
);
  // slots[k] set: a register write is booked k cycles from now
  logic [MAXLAT:1] slots;

  for (genvar k = 1; k <= MAXLAT; k++) begin : g_slot
    logic older;
    if (k < MAXLAT) begin : g_shift
      assign older = slots[k+1];
    end else begin : g_top
      assign older = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (rst)
        slots[k] <= 1'b0;
      else
        slots[k] <= older | (book_en && book_lat == LW'(k + 1));
    end
  end

  assign taken = (check_lat >= LW'(1)) && (check_lat <= LW'(MAXLAT)) && slots[check_lat];
endmodule

// File: rtl/issue_scoreboard.sv
module issue_scoreboard
  import sb_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int REG_W   = $clog2(NREG),
  parameter int LAT_INT = 1,
  parameter int LAT_ADD = 2,
  parameter int LAT_MUL = 4,
  parameter int LAT_DIV = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [UNIT_W-1:0]    in_unit,
  input  logic                 in_has_dst,
  input  logic [REG_W-1:0]     in_dst,
  input  logic [REG_W-1:0]     in_src1,
  input  logic [REG_W-1:0]     in_src2,
  input  logic                 wb_valid,
  input  logic [REG_W-1:0]     wb_reg,
  input  logic [NUM_UNITS-1:0] unit_free,
  output logic                 iss_ok,
  output logic                 iss_stall,
  output logic [NUM_UNITS-1:0] iss_unit
);
  localparam int MAX_AB = (LAT_INT > LAT_ADD) ? LAT_INT : LAT_ADD;
  localparam int MAX_CD = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
  localparam int MAXLAT = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int LW     = $clog2(MAXLAT + 1);

  logic [NREG-1:0]      pend;
  logic [NUM_UNITS-1:0] busy;
  logic [LW-1:0]        lat;
  logic                 slot_taken;
  logic                 unit_hold, raw_hit, waw_hit, wb_clash, grant;

  always_comb begin
    unique case (unit_e'(in_unit))
      U_INT:   lat = LW'(LAT_INT);
      U_ADD:   lat = LW'(LAT_ADD);
      U_MUL:   lat = LW'(LAT_MUL);
      default: lat = LW'(LAT_DIV);
    endcase
  end

  assign unit_hold = busy[in_unit];
  assign raw_hit   = pend[in_src1] | pend[in_src2];
  assign waw_hit   = in_has_dst & pend[in_dst];
  assign wb_clash  = in_has_dst & slot_taken;
  assign grant     = in_valid & ~unit_hold & ~raw_hit & ~waw_hit & ~wb_clash;

  sb_pending #(.NREG(NREG), .REG_W(REG_W)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .set_en  (grant & in_has_dst),
    .set_idx (in_dst),
    .clr_en  (wb_valid),
    .clr_idx (wb_reg),
    .pend    (pend)
  );

  sb_unit_busy #(.NU(NUM_UNITS)) u_busy (
    .clk       (clk),
    .rst       (rst),
    .claim_en  (grant),
    .claim_idx (in_unit),
    .free      (unit_free),
    .busy      (busy)
  );

  sb_wb_slots #(.MAXLAT(MAXLAT), .LW(LW)) u_slots (
    .clk       (clk),
    .rst       (rst),
    .book_en   (grant & in_has_dst),
    .book_lat  (lat),
    .check_lat (lat),
    .taken     (slot_taken)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_ok    <= 1'b0;
      iss_stall <= 1'b0;
      iss_unit  <= '0;
    end else begin
      iss_ok    <= grant;
      iss_stall <= in_valid & ~grant;
      iss_unit  <= grant ? (NUM_UNITS'(1) << in_unit) : '0;
    end
  end
endmodule

// File: rtl/issue_scoreboard_chk.sv
module issue_scoreboard_chk
  import sb_pkg::*;
#(
  parameter int NREG  = 32,
  parameter int REG_W = $clog2(NREG)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [UNIT_W-1:0]    in_unit,
  input logic                 in_has_dst,
  input logic [REG_W-1:0]     in_dst,
  input logic [REG_W-1:0]     in_src1,
  input logic [REG_W-1:0]     in_src2,
  input logic [NREG-1:0]      pend,
  input logic [NUM_UNITS-1:0] busy,
  input logic                 slot_taken,
  input logic                 grant,
  input logic                 iss_ok,
  input logic                 iss_stall,
  input logic [NUM_UNITS-1:0] iss_unit
);
  p_outs_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(iss_unit) && (iss_ok == (|iss_unit)) && !(iss_ok && iss_stall));

  p_busy_block_r3: assert property (@(posedge clk) disable iff (rst)
    in_valid && busy[in_unit] |=> !iss_ok);

  p_claim_r3: assert property (@(posedge clk) disable iff (rst)
    grant |=> busy[$past(in_unit)]);

  p_raw_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && (pend[in_src1] || pend[in_src2]) |=> !iss_ok);

  p_waw_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_has_dst && pend[in_dst] |=> !iss_ok);

  p_slot_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_has_dst && slot_taken |=> !iss_ok);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    grant && in_has_dst |=> pend[$past(in_dst)]);

  p_stall_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (iss_ok != iss_stall));
endmodule

bind issue_scoreboard issue_scoreboard_chk #(.NREG(NREG), .REG_W(REG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_unit    (in_unit),
  .in_has_dst (in_has_dst),
  .in_dst     (in_dst),
  .in_src1    (in_src1),
  .in_src2    (in_src2),
  .pend       (pend),
  .busy       (busy),
  .slot_taken (slot_taken),
  .grant      (grant),
  .iss_ok     (iss_ok),
  .iss_stall  (iss_stall),
  .iss_unit   (iss_unit)
);

// File: tb/issue_scoreboard_bench.sv
module issue_scoreboard_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] UI = 2'd0, UA = 2'd1, UM = 2'd2, UD = 2'd3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_unit = '0;
  logic       in_has_dst = 1'b0;
  logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic       wb_valid = 1'b0;
  logic [4:0] wb_reg = '0;
  logic [3:0] unit_free = '0;
  logic       iss_ok, iss_stall;
  logic [3:0] iss_unit;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  issue_scoreboard u_issue_scoreboard (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_unit(in_unit),
    .in_has_dst(in_has_dst), .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .wb_valid(wb_valid), .wb_reg(wb_reg), .unit_free(unit_free),
    .iss_ok(iss_ok), .iss_stall(iss_stall), .iss_unit(iss_unit)
  );

  task automatic expect_out(input string req, input logic e_ok, input logic e_st,
                            input logic [3:0] e_unit);
    n_vec++;
    if (iss_ok !== e_ok || iss_stall !== e_st || iss_unit !== e_unit) begin
      n_bad++;
      $display("FAIL %s: got ok=%b stall=%b unit=%b, expected ok=%b stall=%b unit=%b",
               req, iss_ok, iss_stall, iss_unit, e_ok, e_st, e_unit);
    end
  endtask

  // Drive one cycle of inputs at the falling edge; return just after the next rising edge.
  task automatic step(input logic v, input logic [1:0] u, input logic hd, input logic [4:0] d,
                      input logic [4:0] s1, input logic [4:0] s2,
                      input logic wv, input logic [4:0] wr, input logic [3:0] fr);
    @(negedge clk);
    in_valid = v; in_unit = u; in_has_dst = hd; in_dst = d; in_src1 = s1; in_src2 = s2;
    wb_valid = wv; wb_reg = wr; unit_free = fr;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input logic wv, input logic [4:0] wr);
    step(1'b0, UI, 1'b0, 5'd0, 5'd0, 5'd0, wv, wr, 4'hF);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    #1;
    expect_out("R1 reset outputs", 1'b0, 1'b0, 4'b0000);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_units();
    step(1'b1, UI, 1'b1, 5'd1, 5'd2, 5'd3, 1'b0, 5'd0, 4'h0);
    expect_out("R1 first instr after reset granted, R2 int", 1'b1, 1'b0, 4'b0001);
    idle(1'b1, 5'd1);
    expect_out("R2 idle", 1'b0, 1'b0, 4'b0000);
    step(1'b1, UA, 1'b1, 5'd2, 5'd5, 5'd6, 1'b0, 5'd0, 4'h0);
    expect_out("R2 add unit", 1'b1, 1'b0, 4'b0010);
    idle(1'b1, 5'd2);
    step(1'b1, UM, 1'b1, 5'd3, 5'd5, 5'd6, 1'b0, 5'd0, 4'h0);
    expect_out("R2 mul unit", 1'b1, 1'b0, 4'b0100);
    idle(1'b1, 5'd3);
    step(1'b1, UD, 1'b1, 5'd4, 5'd5, 5'd6, 1'b0, 5'd0, 4'h0);
    expect_out("R2 div unit", 1'b1, 1'b0, 4'b1000);
    idle(1'b1, 5'd4);
    idle(1'b0, 5'd0);
  endtask

  task automatic t_busy();
    step(1'b1, UD, 1'b1, 5'd20, 5'd1, 5'd2, 1'b0, 5'd0, 4'h0);
    expect_out("R3 div granted", 1'b1, 1'b0, 4'b1000);
    step(1'b1, UD, 1'b1, 5'd21, 5'd1, 5'd2, 1'b0, 5'd0, 4'h0);
    expect_out("R3 div busy stall", 1'b0, 1'b1, 4'b0000);
    step(1'b1, UD, 1'b1, 5'd21, 5'd1, 5'd2, 1'b0, 5'd0, 4'b1000);
    expect_out("R9 free same cycle still stalls", 1'b0, 1'b1, 4'b0000);
    step(1'b1, UD, 1'b1, 5'd21, 5'd1, 5'd2, 1'b0, 5'd0, 4'h0);
    expect_out("R3 div after free", 1'b1, 1'b0, 4'b1000);
    idle(1'b1, 5'd20);
    idle(1'b1, 5'd21);
  endtask

  task automatic t_raw();
    step(1'b1, UA, 1'b1, 5'd10, 5'd1, 5'd2, 1'b0, 5'd0, 4'h0);
    expect_out("R4 producer granted", 1'b1, 1'b0, 4'b0010);
    idle(1'b0, 5'd0);
    step(1'b1, UI, 1'b1, 5'd11, 5'd10, 5'd1, 1'b0, 5'd0, 4'hF);
    expect_out("R4 raw on src1", 1'b0, 1'b1, 4'b0000);
    step(1'b1, UI, 1'b1, 5'd11, 5'd1, 5'd10, 1'b1, 5'd10, 4'hF);
    expect_out("R9 writeback same cycle still stalls (R4 src2)", 1'b0, 1'b1, 4'b0000);
    step(1'b1, UI, 1'b1, 5'd11, 5'd1, 5'd10, 1'b0, 5'd0, 4'h0);
    expect_out("R4 cleared after writeback", 1'b1, 1'b0, 4'b0001);
    idle(1'b1, 5'd11);
  endtask

  task automatic t_waw();
    step(1'b1, UI, 1'b1, 5'd12, 5'd1, 5'd2, 1'b0, 5'd0, 4'h0);
    expect_out("R5 first writer", 1'b1, 1'b0, 4'b0001);
    idle(1'b0, 5'd0);
    step(1'b1, UI, 1'b1, 5'd12, 5'd3, 5'd4, 1'b0, 5'd0, 4'h0);
    expect_out("R5 waw stall", 1'b0, 1'b1, 4'b0000);
    idle(1'b1, 5'd12);
    step(1'b1, UI, 1'b1, 5'd12, 5'd3, 5'd4, 1'b0, 5'd0, 4'h0);
    expect_out("R5 granted after clear", 1'b1, 1'b0, 4'b0001);
    idle(1'b1, 5'd12);
  endtask

  task automatic t_slot();
    step(1'b1, UM, 1'b1, 5'd5, 5'd1, 5'd2, 1'b0, 5'd0, 4'h0);
    expect_out("R6 mul granted", 1'b1, 1'b0, 4'b0100);
    idle(1'b0, 5'd0);
    step(1'b1, UA, 1'b1, 5'd6, 5'd1, 5'd2, 1'b0, 5'd0, 4'h0);
    expect_out("R6 add collides on writeback slot", 1'b0, 1'b1, 4'b0000);
    step(1'b1, UA, 1'b1, 5'd6, 5'd1, 5'd2, 1'b0, 5'd0, 4'h0);
    expect_out("R6 add one cycle later", 1'b1, 1'b0, 4'b0010);
    idle(1'b1, 5'd5);
    idle(1'b1, 5'd6);
  endtask

  task automatic t_nodst();
    step(1'b1, UM, 1'b1, 5'd7, 5'd1, 5'd2, 1'b0, 5'd0, 4'h0);
    expect_out("R8 mul granted", 1'b1, 1'b0, 4'b0100);
    idle(1'b0, 5'd0);
    idle(1'b0, 5'd0);
    step(1'b1, UI, 1'b0, 5'd7, 5'd1, 5'd2, 1'b0, 5'd0, 4'h0);
    expect_out("R8 no-dst skips waw and slot", 1'b1, 1'b0, 4'b0001);
    idle(1'b0, 5'd0);
    step(1'b1, UI, 1'b0, 5'd22, 5'd3, 5'd4, 1'b0, 5'd0, 4'h0);
    expect_out("R8 no-dst granted", 1'b1, 1'b0, 4'b0001);
    idle(1'b0, 5'd0);
    step(1'b1, UI, 1'b1, 5'd23, 5'd22, 5'd1, 1'b0, 5'd0, 4'h0);
    expect_out("R8 no pending set by no-dst", 1'b1, 1'b0, 4'b0001);
    idle(1'b1, 5'd7);
    idle(1'b1, 5'd23);
  endtask

  task automatic t_setwins();
    step(1'b1, UI, 1'b1, 5'd13, 5'd1, 5'd2, 1'b1, 5'd13, 4'h0);
    expect_out("R7 issue beside writeback", 1'b1, 1'b0, 4'b0001);
    idle(1'b0, 5'd0);
    step(1'b1, UI, 1'b1, 5'd14, 5'd13, 5'd1, 1'b0, 5'd0, 4'h0);
    expect_out("R7 set wins over clear", 1'b0, 1'b1, 4'b0000);
    idle(1'b1, 5'd13);
    step(1'b1, UI, 1'b1, 5'd14, 5'd13, 5'd1, 1'b0, 5'd0, 4'h0);
    expect_out("R7 cleared by writeback", 1'b1, 1'b0, 4'b0001);
    idle(1'b1, 5'd14);
  endtask

  task automatic t_war();
    step(1'b1, UA, 1'b1, 5'd15, 5'd16, 5'd17, 1'b0, 5'd0, 4'h0);
    expect_out("R10 reader granted", 1'b1, 1'b0, 4'b0010);
    idle(1'b0, 5'd0);
    step(1'b1, UI, 1'b1, 5'd16, 5'd1, 5'd2, 1'b0, 5'd0, 4'h0);
    expect_out("R10 no war stall", 1'b1, 1'b0, 4'b0001);
    idle(1'b1, 5'd15);
    idle(1'b1, 5'd16);
  endtask

  initial begin
    t_reset();
    t_units();
    t_busy();
    t_raw();
    t_waw();
    t_slot();
    t_nodst();
    t_setwins();
    t_war();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule